// File: doc/BRIEF.md
# Sub-Word Register Access Adapter

This block sits behind a byte-addressed I/O window of 128 bytes and turns every access of one to four bytes into whole-word operations on three banks of 32-bit registers: a 16-entry core bank, an 8-entry DMA bank and a single bus-control word. A read fetches the full word, moves the addressed byte lane down to bit 0 and clears every byte above the requested size. A write that is narrower than a word, or that starts off a word boundary, is turned into a read-modify-write. The current word is fetched, the addressed lanes are replaced, and one full-word write is issued to the aligned address.

The window has holes. Nothing answers there: a write to a hole changes nothing and a read from a hole returns zero. The register banks are kept here as plain storage with no side effects, so the adapter's behaviour can be observed through its own read path and through its write-issue outputs.

Top module: `sub_word_adapter`

## Requirements
- R1: After a synchronous active-low reset every register in all three banks reads as zero, and both `rd_valid` and `wr_stb` are low.
- R2: Byte addresses 0x00 to 0x3F select the core bank, entry `addr>>2`. A write there issues with `wr_region` = 1.
- R3: Byte addresses 0x40 to 0x5F select the DMA bank, entry `(addr-0x40)>>2`. A write there issues with `wr_region` = 2.
- R4: The bus-control word is reached for writes at any byte address from 0x70 to 0x73, decoded on the word-aligned address, with `wr_region` = 3. A read answers only at exactly 0x70; reads at 0x71 to 0x73 return zero.
- R5: Addresses 0x60 to 0x6F and 0x74 to 0x7F are holes. A write there raises no `wr_stb` and changes no register. A read there returns zero.
- R6: `acc_size` holds the byte count minus one (0 means 1 byte, 3 means 4 bytes), and data is little-endian. For a write, lanes `addr[1:0]` up to `addr[1:0]+size` take `acc_wdata` bytes 0, 1, … in order, and every other lane keeps its current value.
- R7: Lanes of a write that would fall beyond bit 31 of the word are dropped. For example, a 4-byte write at offset 3 changes only lane 3, and that lane takes `acc_wdata[7:0]`.
- R8: Read data equals the addressed word shifted right by 8×`addr[1:0]`, with every byte at position `size+1` and above forced to zero.
- R9: A read presented in cycle N sets `rd_valid` and `rd_data` in cycle N+1. A write to a decoded address raises `wr_stb` for exactly its own cycle, together with the region code, the entry index and the merged word. The new value is visible to a read issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 7 | Byte address in the window |
| acc_size | input | 2 | Byte count minus one |
| acc_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Aligned and masked read result |
| wr_stb | output | 1 | Full-word write issued to a bank |
| wr_region | output | 2 | Bank written: 1 core, 2 DMA, 3 bus-control |
| wr_index | output | 4 | Entry written within the bank |
| wr_word | output | 32 | Merged word written |

## Verification
Each bank is first filled with distinct full-word patterns, so that a wrong decode shows up as another entry's data. Narrow writes at every offset and size then separate correct lane steering from a shifted or unmasked merge. A full-size write at offset 3 tells lane dropping apart from wrap-around. Reads at every offset and size check that the shift and the mask act independently. Hole writes, followed by readback of the neighbouring banks, and reads at 0x71 distinguish the asymmetric bus-control decode from a plain word-aligned one.

// File: rtl/adp_pkg.sv
// Shared types for the sub-word access adapter.
// Assumes at most four named regions in the window.
package adp_pkg;
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CORE = 2'd1,
        RGN_DMA  = 2'd2,
        RGN_BCTL = 2'd3
    } region_e;
endpackage

// File: rtl/adp_decode.sv
// Address decoder: maps a byte address onto a region and a word index.
// Assumes the core bank starts at 0, the DMA bank follows it directly,
// and the bus-control word sits at one exact address.
module adp_decode
    import adp_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int CORE_SPAN = 64,
    parameter int DMA_SPAN  = 32,
    parameter int BCTL_ADDR = 112,
    parameter int IDX_W     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] CORE_END = ADDR_W'(CORE_SPAN);
    localparam logic [ADDR_W-1:0] DMA_END  = ADDR_W'(CORE_SPAN + DMA_SPAN);
    localparam logic [ADDR_W-1:0] BCTL     = ADDR_W'(BCTL_ADDR);

    // Region select and word index from the byte address
    always_comb begin
        logic [ADDR_W-1:0] rel;
        rel    = addr - CORE_END;
        region = RGN_NONE;
        idx    = '0;
        if (addr < CORE_END) begin
            region = RGN_CORE;
            idx    = IDX_W'(addr >> 2);
        end else if (addr < DMA_END) begin
            region = RGN_DMA;
            idx    = IDX_W'(rel >> 2);
        end else if (addr == BCTL) begin
            region = RGN_BCTL;
        end
    end
endmodule

// File: rtl/adp_lane_merge.sv
// Write widening: builds byte enables from offset and size, then merges
// the shifted write data into the current word. Lanes past the top of
// the word are dropped.
module adp_lane_merge #(
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  logic [8*LANES-1:0] cur,
    input  logic [8*LANES-1:0] wdata,
    input  logic [OFF_W-1:0]   off,
    input  logic [1:0]         size_m1,
    output logic [LANES-1:0]   be,
    output logic [8*LANES-1:0] word
);
    logic [8*LANES-1:0] shifted;

    // Move write byte 0 to the addressed lane
    assign shifted = wdata << {off, 3'b000};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Lane enabled when inside [off, off+size]
        assign be[l] = (l >= int'(off)) && ((l - int'(off)) <= int'(size_m1));
        // Pick new or kept byte for this lane
        assign word[8*l +: 8] = be[l] ? shifted[8*l +: 8] : cur[8*l +: 8];
    end
endmodule

// File: rtl/adp_read_align.sv
// Read alignment: shifts the full word down by the byte offset and keeps
// only the requested number of bytes.
module adp_read_align #(
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  logic [8*LANES-1:0] full,
    input  logic [OFF_W-1:0]   off,
    input  logic [1:0]         size_m1,
    output logic [8*LANES-1:0] data
);
    logic [8*LANES-1:0] shifted;

    // Bring the addressed lane down to byte 0
    assign shifted = full >> {off, 3'b000};

    for (genvar b = 0; b < LANES; b++) begin : g_byte
        // Keep bytes below the requested size, clear the rest
        assign data[8*b +: 8] = (b <= int'(size_m1)) ? shifted[8*b +: 8] : 8'h00;
    end
endmodule

// File: rtl/sub_word_adapter.sv
// Sub-word access adapter: accepts 1..4 byte accesses on a byte window,
// serves reads aligned and masked one cycle later, and widens writes into
// a single full-word read-modify-write per access. Register banks are
// plain storage. Assumes one access per cycle at most.
module sub_word_adapter
    import adp_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 32,
    parameter int CORE_SPAN = 64,
    parameter int DMA_SPAN  = 32,
    parameter int BCTL_ADDR = 112
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [1:0]           acc_size,
    input  logic [DATA_W-1:0]    acc_wdata,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 wr_stb,
    output logic [1:0]           wr_region,
    output logic [$clog2(CORE_SPAN/4)-1:0] wr_index,
    output logic [DATA_W-1:0]    wr_word
);
    localparam int LANES     = DATA_W / 8;
    localparam int OFF_W     = $clog2(LANES);
    localparam int CORE_REGS = CORE_SPAN / LANES;
    localparam int DMA_REGS  = DMA_SPAN / LANES;
    localparam int IDX_W     = $clog2(CORE_REGS);
    localparam int DMA_IW    = $clog2(DMA_REGS);

    logic [DATA_W-1:0] core_q [CORE_REGS];
    logic [DATA_W-1:0] dma_q  [DMA_REGS];
    logic [DATA_W-1:0] bctl_q;

    logic [ADDR_W-1:0] wr_addr;
    region_e           rd_rgn, wr_rgn;
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [DATA_W-1:0] rd_full, wr_cur, merged, aligned;
    logic [LANES-1:0]  lane_be;
    logic              do_write, do_read;

    // Writes decode on the word-aligned address
    assign wr_addr = {acc_addr[ADDR_W-1:OFF_W], OFF_W'(0)};

    adp_decode #(.ADDR_W(ADDR_W), .CORE_SPAN(CORE_SPAN), .DMA_SPAN(DMA_SPAN),
                 .BCTL_ADDR(BCTL_ADDR), .IDX_W(IDX_W)) u_rd_dec (
        .addr(acc_addr), .region(rd_rgn), .idx(rd_idx)
    );

    adp_decode #(.ADDR_W(ADDR_W), .CORE_SPAN(CORE_SPAN), .DMA_SPAN(DMA_SPAN),
                 .BCTL_ADDR(BCTL_ADDR), .IDX_W(IDX_W)) u_wr_dec (
        .addr(wr_addr), .region(wr_rgn), .idx(wr_idx)
    );

    // Fetch the word a read addresses; holes read as zero
    always_comb begin
        unique case (rd_rgn)
            RGN_CORE: rd_full = core_q[rd_idx];
            RGN_DMA:  rd_full = dma_q[rd_idx[DMA_IW-1:0]];
            RGN_BCTL: rd_full = bctl_q;
            default:  rd_full = '0;
        endcase
    end

    // Fetch the current word a widened write merges into
    always_comb begin
        unique case (wr_rgn)
            RGN_CORE: wr_cur = core_q[wr_idx];
            RGN_DMA:  wr_cur = dma_q[wr_idx[DMA_IW-1:0]];
            RGN_BCTL: wr_cur = bctl_q;
            default:  wr_cur = '0;
        endcase
    end

    adp_lane_merge #(.LANES(LANES), .OFF_W(OFF_W)) u_merge (
        .cur(wr_cur), .wdata(acc_wdata), .off(acc_addr[OFF_W-1:0]),
        .size_m1(acc_size), .be(lane_be), .word(merged)
    );

    adp_read_align #(.LANES(LANES), .OFF_W(OFF_W)) u_align (
        .full(rd_full), .off(acc_addr[OFF_W-1:0]), .size_m1(acc_size),
        .data(aligned)
    );

    assign do_write  = acc_valid && acc_write && (wr_rgn != RGN_NONE) && (|lane_be);
    assign do_read   = acc_valid && !acc_write;
    assign wr_stb    = do_write;
    assign wr_region = wr_rgn;
    assign wr_index  = wr_idx;
    assign wr_word   = merged;

    // Bank storage: one full-word write per accepted access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CORE_REGS; i++) core_q[i] <= '0;
            for (int i = 0; i < DMA_REGS; i++)  dma_q[i]  <= '0;
            bctl_q <= '0;
        end else if (do_write) begin
            unique case (wr_rgn)
                RGN_CORE: core_q[wr_idx] <= merged;
                RGN_DMA:  dma_q[wr_idx[DMA_IW-1:0]] <= merged;
                RGN_BCTL: bctl_q <= merged;
                default:  ;
            endcase
        end
    end

    // Read result register, valid one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= do_read;
            if (do_read) rd_data <= aligned;
        end
    end
endmodule

// File: rtl/sub_word_adapter_chk.sv
// Property checker for the sub-word access adapter, bound to every
// instance of the top module. Observes ports only.
module sub_word_adapter_chk #(
    parameter int ADDR_W = 7,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        acc_size,
    input logic [31:0]       acc_wdata,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              wr_stb,
    input logic [1:0]        wr_region,
    input logic [IDX_W-1:0]  wr_index,
    input logic [31:0]       wr_word
);
    logic in_hole;

    // Hole addresses of the window
    assign in_hole = (acc_addr >= ADDR_W'(8'h60) && acc_addr < ADDR_W'(8'h70)) ||
                     (acc_addr >= ADDR_W'(8'h74));

    p_read_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> rd_valid);

    p_no_stray_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> !rd_valid);

    p_strobe_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (acc_valid && acc_write));

    p_hole_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && in_hole) |-> !wr_stb);

    p_hole_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && in_hole) |=> (rd_data == 32'h0));

    p_byte_read_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_size == 2'd0) |=> (rd_data[31:8] == 24'h0));

    p_core_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && acc_addr < ADDR_W'(8'h40)) |->
        (wr_region == 2'd1 && wr_index == IDX_W'(acc_addr >> 2)));

    p_bctl_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr >= ADDR_W'(8'h70) && acc_addr < ADDR_W'(8'h74))
        |-> (wr_stb && wr_region == 2'd3));

    p_low_byte_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && acc_addr[1:0] == 2'd0) |-> (wr_word[7:0] == acc_wdata[7:0]));
endmodule

bind sub_word_adapter sub_word_adapter_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/sub_word_adapter_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected read results and check
// write issues; a monitor pops and compares read results as they appear.
module sub_word_adapter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [6:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        wr_stb;
    logic [1:0]  wr_region;
    logic [3:0]  wr_index;
    logic [31:0] wr_word;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    logic [31:0] m_core [16];
    logic [31:0] m_dma  [8];
    logic [31:0] m_bc;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    sub_word_adapter dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_stb(wr_stb),
        .wr_region(wr_region), .wr_index(wr_index), .wr_word(wr_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Region of a write, per R2/R3/R4/R5 (decoded on the aligned address)
    function automatic int wr_rgn_of(input logic [6:0] a);
        logic [6:0] w;
        w = {a[6:2], 2'b00};
        if (w < 7'h40) return 1;
        if (w < 7'h60) return 2;
        if (w == 7'h70) return 3;
        return 0;
    endfunction

    function automatic logic [31:0] model_word(input int rgn, input logic [6:0] w);
        if (rgn == 1) return m_core[w >> 2];
        if (rgn == 2) return m_dma[(w - 7'h40) >> 2];
        if (rgn == 3) return m_bc;
        return 32'h0;
    endfunction

    // Read expectation per R4/R5/R8: exact-address bus-control, holes zero
    function automatic logic [31:0] read_exp(input logic [6:0] a, input logic [1:0] sz);
        logic [31:0] full, r;
        int off;
        off = int'(a[1:0]);
        if (a < 7'h40) full = m_core[a >> 2];
        else if (a < 7'h60) full = m_dma[(a - 7'h40) >> 2];
        else if (a == 7'h70) full = m_bc;
        else full = 32'h0;
        r = 32'h0;
        for (int i = 0; i <= int'(sz); i++)
            if (off + i < 4) r[8*i +: 8] = full[8*(off+i) +: 8];
        return r;
    endfunction

    task automatic do_write(input string tag, input logic [6:0] a, input logic [1:0] sz,
                            input logic [31:0] d);
        int rgn, off;
        logic [31:0] cur, nw;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = sz; acc_wdata = d;
        #1;
        rgn = wr_rgn_of(a);
        off = int'(a[1:0]);
        cur = model_word(rgn, {a[6:2], 2'b00});
        nw  = cur;
        for (int l = 0; l < 4; l++)
            if (l >= off && l - off <= int'(sz)) nw[8*l +: 8] = d[8*(l-off) +: 8];
        if (rgn == 0) begin
            chk({tag, " hole strobe"}, {31'h0, wr_stb}, 32'h0);
        end else begin
            chk({tag, " strobe"}, {31'h0, wr_stb}, 32'h1);
            chk({tag, " region"}, {30'h0, wr_region}, rgn[31:0]);
            chk({tag, " word"}, wr_word, nw);
            if (rgn == 1) m_core[a >> 2] = nw;
            else if (rgn == 2) m_dma[({a[6:2], 2'b00} - 7'h40) >> 2] = nw;
            else m_bc = nw;
        end
    endtask

    task automatic do_read(input string tag, input logic [6:0] a, input logic [1:0] sz);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = sz; acc_wdata = '0;
        exp_q.push_back(read_exp(a, sz));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    // Monitor: compare each read result with the queued expectation (R9 latency)
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected rd_valid", 32'h1, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, rd_data, e);
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_core[i] = '0;
        for (int i = 0; i < 8; i++)  m_dma[i]  = '0;
        m_bc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs quiet and banks zero after reset
        chk("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
        chk("R1 wr_stb", {31'h0, wr_stb}, 32'h0);
        do_read("R1 core0", 7'h00, 2'd3);
        do_read("R1 dma7", 7'h5C, 2'd3);
        do_read("R1 bctl", 7'h70, 2'd3);
        // R2: full-word fill of the core bank, then readback
        for (int i = 0; i < 16; i++) do_write("R2 fill", 7'(i*4), 2'd3, 32'hC0DE0000 | 32'(i * 32'h111));
        for (int i = 0; i < 16; i++) do_read("R2 readback", 7'(i*4), 2'd3);
        // R3: DMA bank fill and readback
        for (int i = 0; i < 8; i++) do_write("R3 fill", 7'(8'h40 + i*4), 2'd3, 32'hD0A00000 | 32'(i * 32'h1357));
        for (int i = 0; i < 8; i++) do_read("R3 readback", 7'(8'h40 + i*4), 2'd3);
        // R4: bus-control word, byte write at 0x71, read only at 0x70
        do_write("R4 bctl full", 7'h70, 2'd3, 32'h11223344);
        do_write("R4 bctl byte71", 7'h71, 2'd0, 32'h000000AB);
        do_read("R4 bctl read70", 7'h70, 2'd3);
        do_read("R4 bctl read71 zero", 7'h71, 2'd0);
        do_read("R4 bctl read73 zero", 7'h73, 2'd0);
        // R6: narrow merges at several offsets and sizes
        do_write("R6 byte off1", 7'h05, 2'd0, 32'hFFFFFF5A);
        do_write("R6 half off2", 7'h0A, 2'd1, 32'hFFFFBEEF);
        do_write("R6 three off1", 7'h21, 2'd2, 32'h99A1B2C3);
        do_write("R6 byte off0 dma", 7'h48, 2'd0, 32'h00000077);
        do_read("R6 check off1", 7'h04, 2'd3);
        do_read("R6 check off2", 7'h08, 2'd3);
        do_read("R6 check three", 7'h20, 2'd3);
        do_read("R6 check dma", 7'h48, 2'd3);
        // R7: full-size write at offset 3 drops overflowing lanes
        do_write("R7 overflow", 7'h43, 2'd3, 32'h12345678);
        do_write("R7 half off3", 7'h3F, 2'd1, 32'h0000CAFE);
        do_read("R7 check dma0", 7'h40, 2'd3);
        do_read("R7 check core15", 7'h3C, 2'd3);
        // R5: hole writes ignored, hole reads zero, neighbours unchanged
        do_write("R5 hole 64", 7'h64, 2'd3, 32'hDEADBEEF);
        do_write("R5 hole 6f", 7'h6F, 2'd0, 32'h000000EE);
        do_write("R5 hole 74", 7'h74, 2'd3, 32'hDEADBEEF);
        do_write("R5 hole 7c", 7'h7C, 2'd1, 32'h0000BEEF);
        do_read("R5 hole read 64", 7'h64, 2'd3);
        do_read("R5 hole read 7c", 7'h7C, 2'd3);
        do_read("R5 neighbour dma7", 7'h5C, 2'd3);
        do_read("R5 neighbour bctl", 7'h70, 2'd3);
        // R8: read shift and mask at every offset and size
        for (int o = 0; o < 4; o++)
            for (int s = 0; s < 4; s++)
                do_read("R8 align", 7'(8'h44 + o), 2'(s));
        // R9: write immediately followed by read of the same word
        do_write("R9 wr", 7'h12, 2'd0, 32'h000000E1);
        do_read("R9 rd after wr", 7'h10, 2'd3);
        idle();
        repeat (3) @(negedge clk);
        chk("R9 queue drained", 32'(exp_q.size()), 32'h0);
        chk("R9 idle valid", {31'h0, rd_valid}, 32'h0);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule